// File: doc/BRIEF.md
# Sound chip bus write sequencer

This block sits between a host and a sound synthesizer chip that has a two-port bus. On one port the chip takes a register number. On the other port it takes the value for that register. The host hands over one register write at a time through a valid/ready handshake that carries an 8-bit register number and an 8-bit value. The sequencer splits each write into two bus phases. The address phase drives port 0 and the data phase drives port 1. After each phase the chip needs time to settle before the next access. The wait after the address phase is short and the wait after the data phase is much longer.

The settling time can be counted in two ways, selected for each write by `wait_mode`. In clock mode the sequencer counts system clocks. In read-count mode it fills each wait with dummy status reads of port 0 and counts those reads. The host sees `req_ready` fall when a write is accepted. It rises again only once the long wait has run out. In the idle state the host can also ask for a single status read of port 0. The value comes back with a one-cycle valid pulse.

Top module: `sndbus_write_seq`

## Requirements
- R1: After reset, `bus_cs_n`, `bus_we_n` and `bus_rd_n` are 1 (inactive), `req_ready` is 1 and `rd_valid` is 0.
- R2: The cycle after a write is accepted, the address strobe begins. It lasts STROBE_W cycles with `bus_we_n`=0, `bus_cs_n`=0, `bus_a0`=0 and `bus_dout` equal to the register number. The data strobe comes later. It also lasts STROBE_W cycles, with `bus_a0`=1 and `bus_dout` equal to the value.
- R3: In clock mode (`wait_mode`=0), exactly SHORT_CLKS cycles with all strobes inactive separate the end of the address strobe from the start of the data strobe.
- R4: In clock mode, exactly LONG_CLKS cycles with all strobes inactive follow the data strobe, and then `req_ready` returns to 1.
- R5: In read-count mode (`wait_mode`=1), the short wait is SHORT_READS dummy reads and the long wait is LONG_READS dummy reads. Each dummy read drives `bus_rd_n`=0, `bus_cs_n`=0 and `bus_a0`=0 for RD_W cycles and is followed by one cycle with the strobes inactive.
- R6: `req_ready` stays 0 from the cycle after acceptance until the long wait ends. A request held valid over that time is not accepted a second time.
- R7: The wait mode is taken when the write is accepted. A change of `wait_mode` during the transaction has no effect on that write.
- R8: While the block is idle, a status read request (`rd_req`=1) gives a port-0 read strobe of RD_W cycles. In the next cycle `rd_valid` is 1 for exactly one cycle, and `rd_data` holds the value of `bus_din` sampled in the last strobe cycle.
- R9: A status read request made while a write is in progress is ignored. When a write request and a read request arrive together in the idle state, the write is taken and the read is dropped.
- R10: `bus_we_n` and `bus_rd_n` are never 0 at the same time. `bus_cs_n` is 0 exactly when one of the two strobes is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host write request valid |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_addr | input | 8 | Chip register number |
| req_data | input | 8 | Value to write |
| wait_mode | input | 1 | 0: count clocks, 1: count dummy reads; sampled at acceptance |
| rd_req | input | 1 | Status read request; taken only when idle |
| rd_valid | output | 1 | One-cycle pulse when rd_data is valid |
| rd_data | output | 8 | Status value read from port 0 |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_a0 | output | 1 | Port select: 0 register port, 1 data port |
| bus_dout | output | 8 | Bus write data |
| bus_din | input | 8 | Bus read data |

## Verification
The hardest situations to reach are those where host inputs change while a write is in progress. These are a flip of `wait_mode` after acceptance, a read request that arrives during the waits, and a write request that stays valid through the whole long wait. The stimulus drives each of these during a live transaction. It then compares every cycle of the bus trace against a timeline computed from the mode sampled at acceptance, and it confirms that no read pulse appears and no second acceptance happens.

// File: rtl/sndbus_write_seq.sv
module sndbus_write_seq #(
  parameter int SHORT_CLKS  = 12,
  parameter int LONG_CLKS   = 84,
  parameter int SHORT_READS = 6,
  parameter int LONG_READS  = 35,
  parameter int STROBE_W    = 2,
  parameter int RD_W        = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_data,
  input  logic       wait_mode,
  input  logic       rd_req,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       bus_cs_n,
  output logic       bus_we_n,
  output logic       bus_rd_n,
  output logic       bus_a0,
  output logic [7:0] bus_dout,
  input  logic [7:0] bus_din
);

  localparam int M1   = (SHORT_CLKS > LONG_CLKS) ? SHORT_CLKS : LONG_CLKS;
  localparam int M2   = (SHORT_READS > LONG_READS) ? SHORT_READS : LONG_READS;
  localparam int M3   = (STROBE_W > RD_W) ? STROBE_W : RD_W;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int MAXN = (M12 > M3) ? M12 : M3;
  localparam int CW   = $clog2(MAXN + 1);
  localparam int PW   = $clog2(RD_W + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(RD_W);

  typedef enum logic [2:0] {S_IDLE, S_ASTB, S_AWAIT, S_DSTB, S_DWAIT, S_RSTB} st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [PW-1:0] ph, ph_n;
  logic          mode_q;
  logic [7:0]    data_q;
  logic          tick, accept, we_low_n, rd_low_n, waiting_n;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_ready && req_valid;
  assign tick      = !mode_q || (ph == PH_LAST);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    ph_n  = ph;
    case (st)
      S_IDLE: begin
        if (req_valid) begin
          st_n  = S_ASTB;
          cnt_n = CW'(STROBE_W - 1);
        end else if (rd_req) begin
          st_n  = S_RSTB;
          cnt_n = CW'(RD_W - 1);
        end
      end
      S_ASTB: begin
        if (cnt == '0) begin
          st_n  = S_AWAIT;
          cnt_n = mode_q ? CW'(SHORT_READS - 1) : CW'(SHORT_CLKS - 1);
          ph_n  = '0;
        end else cnt_n = cnt - 1'b1;
      end
      S_AWAIT: begin
        if (mode_q) ph_n = (ph == PH_LAST) ? '0 : ph + 1'b1;
        if (tick) begin
          if (cnt == '0) begin
            st_n  = S_DSTB;
            cnt_n = CW'(STROBE_W - 1);
          end else cnt_n = cnt - 1'b1;
        end
      end
      S_DSTB: begin
        if (cnt == '0) begin
          st_n  = S_DWAIT;
          cnt_n = mode_q ? CW'(LONG_READS - 1) : CW'(LONG_CLKS - 1);
          ph_n  = '0;
        end else cnt_n = cnt - 1'b1;
      end
      S_DWAIT: begin
        if (mode_q) ph_n = (ph == PH_LAST) ? '0 : ph + 1'b1;
        if (tick) begin
          if (cnt == '0) st_n = S_IDLE;
          else cnt_n = cnt - 1'b1;
        end
      end
      S_RSTB: begin
        if (cnt == '0) st_n = S_IDLE;
        else cnt_n = cnt - 1'b1;
      end
      default: st_n = S_IDLE;
    endcase
  end

  assign waiting_n = (st_n == S_AWAIT) || (st_n == S_DWAIT);
  assign we_low_n  = (st_n == S_ASTB) || (st_n == S_DSTB);
  assign rd_low_n  = (st_n == S_RSTB) || (mode_q && waiting_n && (ph_n != PH_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ph       <= '0;
      mode_q   <= 1'b0;
      data_q   <= '0;
      bus_cs_n <= 1'b1;
      bus_we_n <= 1'b1;
      bus_rd_n <= 1'b1;
      bus_a0   <= 1'b0;
      bus_dout <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      ph       <= ph_n;
      bus_we_n <= !we_low_n;
      bus_rd_n <= !rd_low_n;
      bus_cs_n <= !(we_low_n || rd_low_n);
      bus_a0   <= (st_n == S_DSTB);
      if (accept) begin
        mode_q   <= wait_mode;
        data_q   <= req_data;
        bus_dout <= req_addr;
      end else if (st_n == S_DSTB && st != S_DSTB) begin
        bus_dout <= data_q;
      end
      rd_valid <= (st == S_RSTB) && (cnt == '0);
      if (st == S_RSTB && cnt == '0) rd_data <= bus_din;
    end
  end

  // R10
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_we_n && !bus_rd_n));

  // R6
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n || !bus_rd_n) |-> !req_ready);

  // R2
  accept_addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!bus_we_n && !bus_a0 && bus_dout == $past(req_addr)));

  // R2
  strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n && $past(!bus_we_n)) |-> ($stable(bus_dout) && $stable(bus_a0)));

  // R5
  read_port0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_a0);

  // R8
  rd_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: tb/sim_sndbus_write_seq.sv
module sim_sndbus_write_seq;
  localparam int CLK_P = 10;
  localparam int SC = 12, LC = 84, SR = 6, LR = 35, SW = 2, RW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, wait_mode = 1'b0, rd_req = 1'b0;
  logic [7:0] req_addr = '0, req_data = '0, bus_din = '0;
  logic req_ready, rd_valid, bus_cs_n, bus_we_n, bus_rd_n, bus_a0;
  logic [7:0] rd_data, bus_dout;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  sndbus_write_seq #(.SHORT_CLKS(SC), .LONG_CLKS(LC), .SHORT_READS(SR),
    .LONG_READS(LR), .STROBE_W(SW), .RD_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .wait_mode(wait_mode),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_rd_n(bus_rd_n),
    .bus_a0(bus_a0), .bus_dout(bus_dout), .bus_din(bus_din));

  localparam logic [16:0] VECS [0:5] = '{
    {1'b0, 8'h20, 8'h01}, {1'b0, 8'hA0, 8'h44}, {1'b1, 8'hB3, 8'h2F},
    {1'b0, 8'h43, 8'h3F}, {1'b1, 8'hBD, 8'h00}, {1'b1, 8'h80, 8'hFF}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_state(input string req);
    chk({bus_cs_n, bus_we_n, bus_rd_n, req_ready, rd_valid} == 5'b11110, req,
        {bus_cs_n, bus_we_n, bus_rd_n, req_ready, rd_valid}, 5'b11110);
  endtask

  task automatic run_write(input logic m, input logic [7:0] a, input logic [7:0] d,
                           input bit hold, input bit flip, input bit poke_rd);
    int w1, w2, total;
    bit seen_rd;
    w1 = m ? SR * (RW + 1) : SC;
    w2 = m ? LR * (RW + 1) : LC;
    total = 2 * SW + w1 + w2;
    seen_rd = 0;
    while (!req_ready) @(negedge clk);
    wait_mode = m; req_addr = a; req_data = d; req_valid = 1'b1;
    if (poke_rd) rd_req = 1'b1;
    @(posedge clk); @(negedge clk);
    if (!hold) req_valid = 1'b0;
    if (flip) wait_mode = !m;
    for (int k = 0; k < total; k++) begin
      logic ew, er, ea, strobe, wt;
      logic [7:0] ed;
      string tag;
      int j;
      wt = 0; ea = 0; ed = bus_dout; j = 0;
      if (k < SW) begin
        ew = 0; ea = 0; ed = a; tag = "R2";
      end else if (k < SW + w1) begin
        ew = 1; wt = 1; j = k - SW; tag = m ? "R5" : "R3";
      end else if (k < 2 * SW + w1) begin
        ew = 0; ea = 1; ed = d; tag = "R2";
      end else begin
        ew = 1; wt = 1; j = k - 2 * SW - w1; tag = m ? "R5" : "R4";
      end
      if (flip) tag = "R7";
      er = !(wt && m && ((j % (RW + 1)) < RW));
      strobe = !ew || !er;
      chk({bus_cs_n, bus_we_n, bus_rd_n, bus_a0, req_ready, bus_dout} ==
          {!strobe, ew, er, ea, 1'b0, ed}, tag,
          {bus_cs_n, bus_we_n, bus_rd_n, bus_a0, req_ready, bus_dout},
          {!strobe, ew, er, ea, 1'b0, ed});
      chk(!(!bus_we_n && !bus_rd_n), "R10", {bus_we_n, bus_rd_n}, 2'b11);
      if (rd_valid) seen_rd = 1;
      if (k == total - 1) begin req_valid = 1'b0; rd_req = 1'b0; end
      @(negedge clk);
    end
    chk(req_ready && bus_we_n && bus_cs_n, hold ? "R6" : "R4",
        {req_ready, bus_we_n, bus_cs_n}, 3'b111);
    if (rd_valid) seen_rd = 1;
    if (poke_rd) chk(!seen_rd, "R9", seen_rd, 0);
  endtask

  task automatic status_read(input logic [7:0] v);
    bus_din = v;
    while (!req_ready) @(negedge clk);
    rd_req = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_req = 1'b0;
    for (int k = 0; k < RW; k++) begin
      chk({bus_cs_n, bus_rd_n, bus_we_n, bus_a0, rd_valid, req_ready} == 6'b001000, "R8",
          {bus_cs_n, bus_rd_n, bus_we_n, bus_a0, rd_valid, req_ready}, 6'b001000);
      @(negedge clk);
    end
    chk(rd_valid && rd_data == v && req_ready && bus_rd_n, "R8",
        {rd_valid, rd_data, req_ready, bus_rd_n}, {1'b1, v, 1'b1, 1'b1});
    @(negedge clk);
    chk(!rd_valid, "R8", rd_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    idle_state("R1");

    for (int i = 0; i < 6; i++)
      run_write(VECS[i][16], VECS[i][15:8], VECS[i][7:0], 0, 0, 0);

    run_write(1'b0, 8'h55, 8'hAA, 1, 0, 0);   // R6 held request
    run_write(1'b0, 8'h60, 8'h12, 0, 1, 0);   // R7 clock mode, flip to reads
    run_write(1'b1, 8'h61, 8'h34, 0, 1, 0);   // R7 read mode, flip to clocks
    run_write(1'b0, 8'h70, 8'h9C, 0, 0, 1);   // R9 read request during write
    @(negedge clk);
    chk(!rd_valid && req_ready, "R9", {rd_valid, req_ready}, 2'b01);

    status_read(8'hC0);
    status_read(8'h1F);

    req_valid = 1'b1; req_addr = 8'hB0;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    idle_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    idle_state("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule